// File: doc/BRIEF.md
# Serial-Loaded Crossbar Switch Configuration Chain

This block stores the open/closed state for every crosspoint of an analog crossbar that joins 65 terminals to 10 shared buses, 650 crosspoints in all. On each bus, 63 of the terminals are device pins and the other two are the positive and ground supply rails. The pattern is loaded one bit at a time. A single data line is sampled on each falling edge of a serial clock, and each sample enters a shift chain exactly as long as the number of crosspoints.

A global active-high enable chooses what the crosspoint controls show. While the enable is low, every control is held open, whatever the chain holds. This means a new pattern can be loaded with nothing connected. Once the enable is raised, each control follows its stored bit. The chain keeps shifting on clock edges even while the enable is high, so any loading done then changes the switches live. An asynchronous active-low reset empties the chain.

The controls are arranged bus-major. The first bit loaded belongs to bus 1, terminal 1. The 65th bit belongs to bus 1, terminal 65, and the 66th belongs to bus 2, terminal 1. The same pattern continues through bus 10.

Top module: `xbar_cfg_chain`

## Requirements
- R1: While rst_n is low, every chain stage is cleared at once, without any clock edge. With sw_en high, sw_ctrl therefore reads all zeros during reset and right after it.
- R2: ser_data is captured only on a falling edge of ser_clk. A change of ser_data followed by a rising edge of ser_clk does not alter any stored bit.
- R3: Each falling edge of ser_clk moves every stored bit one stage further along a chain of exactly NUM_TERM*NUM_BUS stages (650 by default). A bit is lost on the falling edge that follows the one that carried it to the last stage.
- R4: While sw_en is low, all bits of sw_ctrl are 0, regardless of the chain contents.
- R5: Bits are counted in load order starting from 1. After a full load, sw_ctrl[(b-1)*NUM_TERM + (t-1)] holds loaded bit number (b-1)*NUM_TERM + t, for bus b (1..NUM_BUS) and terminal t (1..NUM_TERM). The bus number therefore selects the high part of the index.
- R6: While sw_en is high, each bit of sw_ctrl equals its stored bit. Lowering and then raising sw_en leaves the stored pattern unchanged.
- R7: Shifting continues while sw_en is high, and sw_ctrl then changes after every falling edge. In particular, sw_ctrl[NUM_TERM*NUM_BUS-1] always shows the most recently captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of the chain |
| ser_clk | input | 1 | Serial clock; data is captured on its falling edge |
| ser_data | input | 1 | Serial configuration data |
| sw_en | input | 1 | Global enable; when low, every crosspoint is open |
| sw_ctrl | output | NUM_TERM*NUM_BUS | Crosspoint controls, bus-major, 1 = closed |

## Verification
The clocked assertions sample on falling edges of ser_clk. They assume that sw_en does not change between two consecutive falling edges when it is high at both of them, and that ser_data is steady at each falling edge. The bench meets both assumptions. It changes ser_data and sw_en only while the serial clock is held high, well away from any falling edge. It releases reset only while the serial clock is idle. It also deliberately changes data just before a rising edge, to show that rising edges are ignored.

// File: rtl/xbar_cfg_pkg.sv
package xbar_cfg_pkg;

   // Flat crosspoint slot for a zero-based bus and terminal, bus-major.
   function automatic int unsigned slot_of(input int unsigned bus_i,
                                           input int unsigned term_i,
                                           input int unsigned n_term);
      return bus_i * n_term + term_i;
   endfunction

   // Chain stage that holds a given slot once a complete pattern is loaded:
   // the first bit loaded travels to the far end of the chain.
   function automatic int unsigned stage_of(input int unsigned slot,
                                            input int unsigned depth);
      return depth - 1 - slot;
   endfunction

endpackage

// File: rtl/xbar_shift_chain.sv
module xbar_shift_chain #(
   parameter int unsigned DEPTH = 650
) (
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_data,
   output logic [DEPTH-1:0] stage_q
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xbar_shift_chain: DEPTH must be at least 2");
   end

   // Stage 0 takes the line; each later stage takes its predecessor.
   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_head
         assign d_in = ser_data;
      end else begin : g_body
         assign d_in = stage_q[i-1];
      end
      always_ff @(negedge ser_clk or negedge rst_n) begin
         if (!rst_n) stage_q[i] <= 1'b0;
         else        stage_q[i] <= d_in;
      end
   end

endmodule

// File: rtl/xbar_switch_map.sv
module xbar_switch_map
   import xbar_cfg_pkg::*;
#(
   parameter int unsigned NUM_TERM = 65,
   parameter int unsigned NUM_BUS  = 10,
   localparam int unsigned DEPTH   = NUM_TERM * NUM_BUS
) (
   input  logic             sw_en,
   input  logic [DEPTH-1:0] stage_q,
   output logic [DEPTH-1:0] sw_ctrl
);

   if (NUM_TERM < 2 || NUM_BUS < 1) begin : g_bad_shape
      $error("xbar_switch_map: need NUM_TERM >= 2 and NUM_BUS >= 1");
   end

   // One gated control per bus/terminal pair.
   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
         localparam int unsigned SLOT  = slot_of(b, t, NUM_TERM);
         localparam int unsigned STAGE = stage_of(SLOT, DEPTH);
         assign sw_ctrl[SLOT] = sw_en & stage_q[STAGE];
      end
   end

endmodule

// File: rtl/xbar_cfg_chain.sv
module xbar_cfg_chain #(
   parameter int unsigned NUM_TERM = 65,
   parameter int unsigned NUM_BUS  = 10,
   localparam int unsigned DEPTH   = NUM_TERM * NUM_BUS
) (
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_data,
   input  logic             sw_en,
   output logic [DEPTH-1:0] sw_ctrl
);

   if (DEPTH < 2) begin : g_bad_top
      $error("xbar_cfg_chain: crossbar must have at least two crosspoints");
   end

   logic [DEPTH-1:0] stage_q;

   xbar_shift_chain #(.DEPTH(DEPTH)) u_chain (
      .rst_n    (rst_n),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .stage_q  (stage_q)
   );

   xbar_switch_map #(.NUM_TERM(NUM_TERM), .NUM_BUS(NUM_BUS)) u_map (
      .sw_en    (sw_en),
      .stage_q  (stage_q),
      .sw_ctrl  (sw_ctrl)
   );

   // Falling edges seen since reset, saturating at 2; checker use only.
   logic [1:0] edges_seen;
   always_ff @(negedge ser_clk or negedge rst_n) begin
      if (!rst_n)                 edges_seen <= 2'd0;
      else if (edges_seen != 2'd2) edges_seen <= edges_seen + 2'd1;
   end

   // R1: the chain is empty when reset lets go.
   always @(posedge rst_n) begin
      a_r1_clear: assert (sw_ctrl == '0)
         else $error("R1: controls not clear at reset release");
   end

   // R2/R7: newest control shows the bit captured on the previous fall.
   a_r2_entry: assert property (@(negedge ser_clk) disable iff (!rst_n)
      (edges_seen != 2'd0 && sw_en) |-> sw_ctrl[DEPTH-1] == $past(ser_data))
      else $error("R2: captured bit missing at chain entry");

   // R3: each fall moves every control one slot toward slot 0.
   a_r3_advance: assert property (@(negedge ser_clk) disable iff (!rst_n)
      (edges_seen == 2'd2 && sw_en && $past(sw_en))
         |-> sw_ctrl[DEPTH-2:0] == $past(sw_ctrl[DEPTH-1:1]))
      else $error("R3: chain did not advance by one stage");

   // R4: disabled matrix is fully open.
   a_r4_open: assert property (@(negedge ser_clk) disable iff (!rst_n)
      !sw_en |-> sw_ctrl == '0)
      else $error("R4: switch closed while disabled");

endmodule

// File: tb/xbar_cfg_chain_tb.sv
module xbar_cfg_chain_tb;

   localparam int unsigned NT = 65;
   localparam int unsigned NB = 10;
   localparam int unsigned N  = NT * NB;

   logic clk = 1'b0;
   logic shift_on = 1'b0;
   logic rst_n = 1'b0;
   logic ser_data = 1'b0;
   logic sw_en = 1'b0;
   logic ser_clk;
   logic [N-1:0] sw_ctrl;
   logic [N-1:0] mdl;     // expected stored pattern in control order
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz
   assign ser_clk = clk | ~shift_on;

   xbar_cfg_chain #(.NUM_TERM(NT), .NUM_BUS(NB)) u_dut (
      .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .sw_en(sw_en), .sw_ctrl(sw_ctrl)
   );

   function automatic int unsigned slot(input int unsigned b, input int unsigned t);
      return (b - 1) * NT + (t - 1);
   endfunction

   task automatic chk(input string req, input logic [N-1:0] exp);
      checks++;
      if (sw_ctrl !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, sw_ctrl, exp);
      end
   endtask

   task automatic chk_bit(input string req, input int unsigned idx, input logic exp);
      checks++;
      if (sw_ctrl[idx] !== exp) begin
         errors++;
         $display("FAIL %s bit %0d act=%b exp=%b", req, idx, sw_ctrl[idx], exp);
      end
   endtask

   // One falling edge capturing d; data flips before the following rise.
   task automatic shift_bit(input logic d);
      @(posedge clk); #1;
      ser_data = d;
      shift_on = 1'b1;
      @(negedge clk); #1;
      mdl = {d, mdl[N-1:1]};
      ser_data = ~d;
      #1 shift_on = 1'b0;
      #1;
   endtask

   task automatic t_reset;
      sw_en = 1'b1; #1;
      chk("R1 during reset", '0);
      #10 rst_n = 1'b1; #1;
      chk("R1 after release", '0);
      mdl = '0;
   endtask

   task automatic t_rise_ignored;
      shift_bit(1'b1);   // ser_data already flipped to 0 and a rise occurred
      chk_bit("R2 rise ignored", N - 1, 1'b1);
      chk("R2 single bit", mdl);
   endtask

   task automatic t_live;
      for (int k = 0; k < 4; k++) begin
         shift_bit(1'b0);
         chk_bit("R7 live walk", N - 2 - k, 1'b1);
      end
      chk("R7 live pattern", mdl);
   endtask

   task automatic t_async_clear;
      shift_bit(1'b1); shift_bit(1'b1);
      #2 rst_n = 1'b0; #1;
      chk("R1 async clear", '0);
      mdl = '0;
      #5 rst_n = 1'b1; #1;
      chk("R1 stays clear", '0);
   endtask

   task automatic t_disabled_load;
      sw_en = 1'b0;
      for (int k = 0; k < 20; k++) begin
         shift_bit(k[0] | k[2]);
         if (k % 5 == 4) chk("R4 open while loading", '0);
      end
      sw_en = 1'b1; #1;
      chk("R6 reveal", mdl);
      sw_en = 1'b0; #1;
      chk("R4 disable again", '0);
      sw_en = 1'b1; #1;
      chk("R6 kept after toggle", mdl);
   endtask

   task automatic t_mapping;
      logic [N-1:0] exp = '0;
      sw_en = 1'b0;
      exp[slot(1, 1)]   = 1'b1;
      exp[slot(1, NT)]  = 1'b1;
      exp[slot(2, 1)]   = 1'b1;
      exp[slot(5, 33)]  = 1'b1;
      exp[slot(NB, NT)] = 1'b1;
      // loaded bit k (1-based) belongs to slot k-1
      for (int k = 1; k <= int'(N); k++) shift_bit(exp[k-1]);
      chk("R4 open after full load", '0);
      sw_en = 1'b1; #1;
      chk("R5 bus-major map", exp);
      chk_bit("R5 bus2 term1 is bit 66", 65, 1'b1);
      chk_bit("R5 bus1 term2 empty", 1, 1'b0);
   endtask

   task automatic t_depth;
      sw_en = 1'b0;
      shift_bit(1'b1);
      for (int k = 0; k < int'(N) - 1; k++) shift_bit(1'b0);
      sw_en = 1'b1; #1;
      chk_bit("R3 first bit at far end", 0, 1'b1);
      chk("R3 only one bit", {{(N-1){1'b0}}, 1'b1});
      shift_bit(1'b0);
      chk("R3 dropped after last stage", '0);
   endtask

   initial begin
      mdl = '0;
      t_reset();
      t_rise_ignored();
      t_live();
      t_async_clear();
      t_disabled_load();
      t_mapping();
      t_depth();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule